// File: doc/BRIEF.md
# DMA channel transfer controller

A single-channel DMA engine that copies a programmed number of data items between a peripheral side and a memory side. Software programs a control word, a peripheral-side address, a memory-side address and an item count through a small register port. Setting the enable bit starts the channel. Each item is moved as one read followed by one write on a simple bus master port that has at most one access in flight.

A direction bit decides which side is the source. The size and increment settings always belong to their own side, so they follow that side when the roles swap. Outside memory-to-memory mode, each item waits for a pulse on the peripheral request input. In memory-to-memory mode, items run back to back.

The engine raises three flags: half-transfer, transfer-complete and transfer-error. Each flag can drive the interrupt output. A bus error stops the channel and keeps it locked off until software clears the error flag. Circular mode reloads the count and both addresses when the count runs out. A 2-bit priority field is held for an external arbiter.

Top module: `dma_chan_top`

## Requirements
- R1: After reset, every readable register reads 0, and `irq`, `busReq` and `prio` are 0. The registers are selected by `regAddr`:
  - 0 = control word
  - 1 = peripheral address, reads the current value
  - 2 = memory address, reads the current value
  - 3 = count; a write sets the programmed count, a read returns the remaining count
  - 4 = flags, read only
  - 5 = flag clear, write only
- R2: The control word has these bit positions:
  - bit 0 enable
  - bit 1 complete-interrupt enable
  - bit 2 half-interrupt enable
  - bit 3 error-interrupt enable
  - bit 4 direction
  - bit 5 circular
  - bit 6 peripheral increment
  - bit 7 memory increment
  - bits 9:8 peripheral size
  - bits 11:10 memory size
  - bits 13:12 priority
  - bit 14 memory-to-memory

  Writing enable from 0 to 1 loads the current addresses and the remaining count from their programmed values. Outside memory-to-memory mode, no bus access starts until a pulse arrives on `perReq`, and each item needs its own pulse. In memory-to-memory mode, items run without any request.
- R3: With direction 0, the item is read at the peripheral address and written at the memory address. With direction 1, it is read at the memory address and written at the peripheral address.
- R4: The size codes are 00 = 8 bits, 01 = 16 bits and 10 = 32 bits. `busSize` carries the size of the side being accessed. Data travels on the low lanes. The read data is cut to the source width, then cut or zero-extended to the destination width.
- R5: After each item, an address whose increment bit is set advances by the byte size of its own side: 1, 2 or 4. An address whose increment bit is clear stays unchanged.
- R6: The remaining count drops by one per completed item. The half flag (flags bit 1) sets when the remaining count becomes the programmed count divided by two, rounded down. The complete flag (flags bit 0) sets when it becomes 0. Outside circular mode, enable then clears.
- R7: In circular mode, the item that brings the count to 0 reloads the count and both addresses from their programmed values, and enable stays 1.
- R8: `busReq` stays high, with `busAddr` and `busWe` unchanged, until `busAck`, so only one access is ever outstanding.
- R9: `busErr` together with `busAck` sets the error flag (flags bit 2), clears enable and starts no further access.
- R10: While the error flag is set, writes that set enable are ignored. Writing 1 to a bit of the flag-clear register (bit 0 complete, bit 1 half, bit 2 error) clears that flag.
- R11: Writing enable = 1 with either size field at 11 sets the error flag on the next cycle, leaves enable at 0 and starts no bus access.
- R12: `irq` is high when any flag is set together with its interrupt enable. `prio` shows the stored priority field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| perReq | input | 1 | Peripheral request pulse |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | Bus access is a write |
| busAddr | output | 32 | Bus byte address |
| busSize | output | 2 | Bus access size code |
| busWdata | output | 32 | Bus write data |
| busRdata | input | 32 | Bus read data, valid with busAck |
| busAck | input | 1 | Access done |
| busErr | input | 1 | Access failed, valid with busAck |
| irq | output | 1 | Channel interrupt |
| prio | output | 2 | Channel priority level |

## Verification
Two pairs of events can land on the same cycle.

The first pair is the half-transfer and complete flags. With a programmed count of 1, half of the count is 0, so the single item that finishes the transfer must raise both flags at the same edge. The bench runs a one-item transfer with only the half interrupt enabled. It checks that both flags read back set, then clears only the half flag and checks that `irq` drops while the complete flag stays set.

The second pair is the circular reload and the complete flag, which coincide on the final item of a circular pass. The bench checks that the count and the addresses read back at their programmed values, that enable stays set, and that the next item writes to the reloaded address.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_PER  = 3'd1;
  localparam logic [2:0] REG_MEM  = 3'd2;
  localparam logic [2:0] REG_CNT  = 3'd3;
  localparam logic [2:0] REG_FLAG = 3'd4;
  localparam logic [2:0] REG_CLR  = 3'd5;

  localparam logic [1:0] SZ_BAD = 2'b11;

  // control word, enable at bit 0
  typedef struct packed {
    logic       m2m;
    logic [1:0] prio;
    logic [1:0] memSz;
    logic [1:0] perSz;
    logic       memInc;
    logic       perInc;
    logic       circ;
    logic       dir;
    logic       teIe;
    logic       htIe;
    logic       tcIe;
    logic       en;
  } ctrlReg_t;

  localparam int CTRL_W = $bits(ctrlReg_t);

  // strobes from control to datapath
  typedef struct packed {
    logic loadPer;
    logic loadMem;
    logic loadCnt;
    logic reload;
    logic capture;
    logic step;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dmac_dpath.sv
module dmac_dpath
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  ctrlReg_t          cfg,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [1:0]        srcSz,
  output logic [1:0]        dstSz,
  output logic [ADDR_W-1:0] curPer,
  output logic [ADDR_W-1:0] curMem,
  output logic [CNT_W-1:0]  remCnt,
  output logic [CNT_W-1:0]  halfCnt,
  output logic [DATA_W-1:0] wrData
);

  logic [ADDR_W-1:0] progPer, progMem;
  logic [CNT_W-1:0]  progCnt;
  logic [DATA_W-1:0] dataLatch;
  logic [ADDR_W-1:0] perStep, memStep;

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] sz);
    case (sz)
      2'b00:   return DATA_W'(8'hFF);
      2'b01:   return DATA_W'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

  assign halfCnt = progCnt >> 1;
  assign srcSz   = cfg.dir ? cfg.memSz : cfg.perSz;
  assign dstSz   = cfg.dir ? cfg.perSz : cfg.memSz;
  assign srcAddr = cfg.dir ? curMem : curPer;
  assign dstAddr = cfg.dir ? curPer : curMem;
  assign perStep = cfg.perInc ? ADDR_W'(sizeBytes(cfg.perSz)) : '0;
  assign memStep = cfg.memInc ? ADDR_W'(sizeBytes(cfg.memSz)) : '0;
  assign wrData  = dataLatch & laneMask(dstSz);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progPer <= '0;
      progMem <= '0;
      progCnt <= '0;
    end else begin
      if (stb.loadPer) progPer <= regWdata[ADDR_W-1:0];
      if (stb.loadMem) progMem <= regWdata[ADDR_W-1:0];
      if (stb.loadCnt) progCnt <= regWdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPer <= '0;
      curMem <= '0;
      remCnt <= '0;
    end else if (stb.reload) begin
      curPer <= progPer;
      curMem <= progMem;
      remCnt <= progCnt;
    end else if (stb.step) begin
      curPer <= curPer + perStep;
      curMem <= curMem + memStep;
      remCnt <= remCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataLatch <= '0;
    else if (stb.capture) dataLatch <= busRdata & laneMask(srcSz);
  end

  p_fixed_per_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.step && !stb.reload && !cfg.perInc |=> $stable(curPer));
  p_fixed_mem_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.step && !stb.reload && !cfg.memInc |=> $stable(curMem));
  p_cnt_dec_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.step && !stb.reload |=> remCnt == CNT_W'($past(remCnt) - CNT_W'(1)));

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [CTRL_W-1:0] regWbits,
  input  logic              perReq,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [CNT_W-1:0]  remCnt,
  input  logic [CNT_W-1:0]  halfCnt,
  output ctrlReg_t          cfg,
  output strobe_t           stb,
  output logic [2:0]        flags,
  output logic              busReq,
  output logic              busWe,
  output logic              irq
);

  state_t   state, stateNxt;
  ctrlReg_t newCfg;
  logic wrCtrl, wrClr, badSize, startOk, go, reqPend;
  logic errAck, doneItem, lastItem, readOk;
  logic setTc, setHt, setTe;
  logic [2:0] clrBits;

  assign newCfg   = ctrlReg_t'(regWbits);
  assign wrCtrl   = regWr && (regAddr == REG_CTRL);
  assign wrClr    = regWr && (regAddr == REG_CLR);
  assign clrBits  = wrClr ? regWbits[2:0] : 3'b000;
  assign badSize  = (newCfg.perSz == SZ_BAD) || (newCfg.memSz == SZ_BAD);
  assign startOk  = wrCtrl && newCfg.en && !cfg.en && !flags[2] && !badSize;

  assign busReq   = (state != ST_IDLE);
  assign busWe    = (state == ST_WRITE);
  assign errAck   = busReq && busAck && busErr;
  assign readOk   = (state == ST_READ) && busAck && !busErr;
  assign doneItem = (state == ST_WRITE) && busAck && !busErr;
  assign lastItem = doneItem && (remCnt == CNT_W'(1));
  assign go       = cfg.en && (remCnt != '0) && (cfg.m2m || reqPend);

  assign setTc = lastItem;
  assign setHt = doneItem && (CNT_W'(remCnt - CNT_W'(1)) == halfCnt);
  assign setTe = errAck || (wrCtrl && newCfg.en && !flags[2] && badSize);

  always_comb begin
    stb         = '0;
    stb.loadPer = regWr && (regAddr == REG_PER);
    stb.loadMem = regWr && (regAddr == REG_MEM);
    stb.loadCnt = regWr && (regAddr == REG_CNT);
    stb.reload  = startOk || (lastItem && cfg.circ);
    stb.capture = readOk;
    stb.step    = doneItem;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (go) stateNxt = ST_READ;
      ST_READ:  if (busAck) stateNxt = (busErr || !cfg.en) ? ST_IDLE : ST_WRITE;
      ST_WRITE: if (busAck) stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPend <= 1'b0;
    else if (!cfg.en || (state == ST_IDLE && go)) reqPend <= 1'b0;
    else if (perReq) reqPend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else begin
      if (wrCtrl) begin
        cfg    <= newCfg;
        cfg.en <= newCfg.en && (cfg.en || startOk);
      end
      if (errAck || (lastItem && !cfg.circ)) cfg.en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrBits) | {setTe, setHt, setTc};
  end

  assign irq = |(flags & {cfg.teIe, cfg.htIe, cfg.tcIe});

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busWe));
  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    errAck |=> !cfg.en && flags[2] && !busReq);
  p_te_lock_r10: assert property (@(posedge clk) disable iff (!rstN)
    flags[2] && !clrBits[2] |=> !cfg.en);
  p_done_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    lastItem && !cfg.circ |=> !cfg.en && flags[0]);
  p_circ_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    lastItem && cfg.circ && cfg.en && !wrCtrl |=> cfg.en && flags[0]);
  p_bad_size_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl && newCfg.en && badSize && !cfg.en && !busReq |=> !cfg.en && flags[2] && !busReq);

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              perReq,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck,
  input  logic              busErr,
  output logic              irq,
  output logic [1:0]        prio
);

  ctrlReg_t cfg;
  strobe_t  stb;
  logic [2:0]        flags;
  logic [CNT_W-1:0]  remCnt, halfCnt;
  logic [ADDR_W-1:0] srcAddr, dstAddr, curPer, curMem;
  logic [1:0]        srcSz, dstSz;

  dmac_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWbits(regWdata[CTRL_W-1:0]), .perReq(perReq),
    .busAck(busAck), .busErr(busErr), .remCnt(remCnt), .halfCnt(halfCnt),
    .cfg(cfg), .stb(stb), .flags(flags), .busReq(busReq), .busWe(busWe),
    .irq(irq)
  );

  dmac_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .regWdata(regWdata),
    .busRdata(busRdata), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .srcSz(srcSz), .dstSz(dstSz), .curPer(curPer), .curMem(curMem),
    .remCnt(remCnt), .halfCnt(halfCnt), .wrData(busWdata)
  );

  assign busAddr = busWe ? dstAddr : srcAddr;
  assign busSize = busWe ? dstSz : srcSz;
  assign prio    = cfg.prio;

  always_comb begin
    case (regAddr)
      REG_CTRL: regRdata = DATA_W'(cfg);
      REG_PER:  regRdata = DATA_W'(curPer);
      REG_MEM:  regRdata = DATA_W'(curMem);
      REG_CNT:  regRdata = DATA_W'(remCnt);
      REG_FLAG: regRdata = DATA_W'(flags);
      default:  regRdata = '0;
    endcase
  end

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> $stable(busAddr) && $stable(busSize));

endmodule

// File: tb/tb_dma_chan_top.sv
module tb_dma_chan_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        perReq = 1'b0;
  logic        busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic [1:0]  busSize;
  logic [31:0] busRdata = '0;
  logic        busAck = 1'b0;
  logic        busErr = 1'b0;
  logic        irq;
  logic [1:0]  prio;

  int numChecks = 0;
  int numFail = 0;
  int grants = 0;
  bit done = 0;
  bit errArm = 0;
  logic [31:0] errAddr = '0;
  logic [63:0] expQ[$];

  always #10 clk = ~clk;

  dma_chan_top dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .perReq(perReq),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck),
    .busErr(busErr), .irq(irq), .prio(prio)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (!ok) begin
      numFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdModel(input logic [31:0] a);
    return {8'hF0 ^ a[7:0], a[7:0] + 8'h33, 8'h5A ^ a[7:0], a[7:0] + 8'h01};
  endfunction

  function automatic logic [31:0] szMask(input logic [1:0] sz);
    return (sz == 2'b00) ? 32'hFF : (sz == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mkCtrl(input bit en, input bit tcIe, input bit htIe,
      input bit teIe, input bit dir, input bit circ, input bit pInc, input bit mInc,
      input logic [1:0] pSz, input logic [1:0] mSz, input logic [1:0] pr, input bit m2m);
    return {17'd0, m2m, pr, mSz, pSz, mInc, pInc, circ, dir, teIe, htIe, tcIe, en};
  endfunction

  // driver side of the scoreboard
  task automatic expectItem(input logic [31:0] srcA, input logic [1:0] sSz,
                            input logic [31:0] dstA, input logic [1:0] dSz);
    expQ.push_back({dstA, rdModel(srcA) & szMask(sSz) & szMask(dSz)});
  endtask

  // bus responder and monitor
  always @(negedge clk) begin
    if (busAck) begin
      busAck = 1'b0;
      busErr = 1'b0;
    end else if (busReq) begin
      busAck = 1'b1;
      grants++;
      busErr = errArm && (busAddr == errAddr);
      if (!busWe) begin
        busRdata = rdModel(busAddr);
      end else if (!busErr) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 unexpected write", busAddr, 32'hFFFF_FFFF);
        end else begin
          logic [63:0] e;
          e = expQ.pop_front();
          chk(busAddr == e[63:32], "R3 R5 write address", busAddr, e[63:32]);
          chk(busWdata == e[31:0], "R4 write data", busWdata, e[31:0]);
        end
      end
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulseReq();
    @(negedge clk); perReq = 1'b1;
    @(negedge clk); perReq = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (expQ.size() == 0 && !busReq) break;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", numChecks - numFail, numChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      numChecks++;
      numFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int g0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(irq == 0 && busReq == 0 && prio == 0, "R1 outputs reset", {irq, busReq, prio}, 0);

    // dir 0, per 32-bit fixed, mem 8-bit incrementing, four request-paced items
    regWrite(3'd1, 32'h100);
    regWrite(3'd2, 32'h200);
    regWrite(3'd3, 32'd4);
    for (int i = 0; i < 4; i++) expectItem(32'h100, 2'b10, 32'h200 + 32'(i), 2'b00);
    g0 = grants;
    regWrite(3'd0, mkCtrl(1, 1, 1, 0, 0, 0, 0, 1, 2'b10, 2'b00, 2'b00, 0));
    repeat (15) @(negedge clk);
    chk(grants == g0, "R2 no access without request", grants, g0);
    pulseReq(); waitIdle();
    pulseReq(); waitIdle();
    regRead(3'd4, v);
    chk(v == 32'h2, "R6 half flag at count/2", v, 32'h2);
    regRead(3'd3, v);
    chk(v == 32'd2, "R6 remaining count", v, 2);
    pulseReq(); waitIdle();
    pulseReq(); waitIdle();
    regRead(3'd4, v);
    chk(v == 32'h3, "R6 complete flag", v, 32'h3);
    regRead(3'd0, v);
    chk(v[0] == 1'b0, "R6 enable cleared at completion", v[0], 0);
    regRead(3'd1, v);
    chk(v == 32'h100, "R5 fixed peripheral address", v, 32'h100);
    regRead(3'd2, v);
    chk(v == 32'h204, "R5 memory address step 1", v, 32'h204);
    chk(irq == 1'b1, "R12 irq on enabled flags", irq, 1);
    regWrite(3'd5, 32'h3);
    regRead(3'd4, v);
    chk(v == 0 && irq == 0, "R10 flags cleared by write-one", {v[30:0], irq}, 0);

    // memory-to-memory, dir 1: source mem 16-bit, destination per 32-bit
    regWrite(3'd1, 32'h400);
    regWrite(3'd2, 32'h300);
    regWrite(3'd3, 32'd3);
    for (int i = 0; i < 3; i++) expectItem(32'h300 + 32'(2 * i), 2'b01, 32'h400 + 32'(4 * i), 2'b10);
    regWrite(3'd0, mkCtrl(1, 0, 0, 0, 1, 0, 1, 1, 2'b10, 2'b01, 2'b01, 1));
    waitIdle();
    regRead(3'd1, v);
    chk(v == 32'h40C, "R3 R5 peripheral destination advanced by 4", v, 32'h40C);
    regRead(3'd2, v);
    chk(v == 32'h306, "R5 memory source advanced by 2", v, 32'h306);
    regRead(3'd4, v);
    chk(v == 32'h3, "R6 flags after m2m run", v, 3);
    chk(irq == 1'b0, "R12 irq masked", irq, 0);
    regWrite(3'd5, 32'h7);

    // one item: half and complete on the same edge
    regWrite(3'd1, 32'h500);
    regWrite(3'd2, 32'h600);
    regWrite(3'd3, 32'd1);
    expectItem(32'h500, 2'b00, 32'h600, 2'b00);
    regWrite(3'd0, mkCtrl(1, 0, 1, 0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b00, 1));
    waitIdle();
    regRead(3'd4, v);
    chk(v == 32'h3, "R6 half and complete together", v, 3);
    chk(irq == 1'b1, "R12 irq from half flag", irq, 1);
    regWrite(3'd5, 32'h2);
    regRead(3'd4, v);
    chk(v == 32'h1 && irq == 0, "R10 R12 only half cleared", {v[30:0], irq}, 32'h2);
    regWrite(3'd5, 32'h1);

    // circular, request-paced, priority 10
    regWrite(3'd1, 32'h700);
    regWrite(3'd2, 32'h800);
    regWrite(3'd3, 32'd2);
    expectItem(32'h700, 2'b00, 32'h800, 2'b01);
    expectItem(32'h701, 2'b00, 32'h802, 2'b01);
    expectItem(32'h700, 2'b00, 32'h800, 2'b01);
    regWrite(3'd0, mkCtrl(1, 0, 0, 0, 0, 1, 1, 1, 2'b00, 2'b01, 2'b10, 0));
    chk(prio == 2'b10, "R12 priority exported", prio, 2);
    pulseReq(); waitIdle();
    pulseReq(); waitIdle();
    regRead(3'd0, v);
    chk(v[0] == 1'b1, "R7 stays enabled", v[0], 1);
    regRead(3'd3, v);
    chk(v == 32'd2, "R7 count reloaded", v, 2);
    regRead(3'd1, v);
    chk(v == 32'h700, "R7 peripheral address reloaded", v, 32'h700);
    regRead(3'd4, v);
    chk(v[0] == 1'b1, "R7 complete flag on wrap", v[0], 1);
    pulseReq(); waitIdle();
    regWrite(3'd0, mkCtrl(0, 0, 0, 0, 0, 1, 1, 1, 2'b00, 2'b01, 2'b10, 0));
    regWrite(3'd5, 32'h7);

    // bus error on the second write
    regWrite(3'd1, 32'h900);
    regWrite(3'd2, 32'hA00);
    regWrite(3'd3, 32'd4);
    errArm = 1; errAddr = 32'hA04;
    expectItem(32'h900, 2'b10, 32'hA00, 2'b10);
    regWrite(3'd0, mkCtrl(1, 0, 0, 1, 0, 0, 1, 1, 2'b10, 2'b10, 2'b00, 1));
    waitIdle();
    regRead(3'd4, v);
    chk(v == 32'h4, "R9 error flag", v, 4);
    regRead(3'd0, v);
    chk(v[0] == 1'b0, "R9 enable cleared by error", v[0], 0);
    chk(irq == 1'b1, "R12 irq on error", irq, 1);
    errArm = 0;
    g0 = grants;
    regWrite(3'd0, mkCtrl(1, 0, 0, 1, 0, 0, 1, 1, 2'b10, 2'b10, 2'b00, 1));
    repeat (20) @(negedge clk);
    regRead(3'd0, v);
    chk(v[0] == 1'b0 && grants == g0, "R10 enable ignored while error set", {v[0], 8'(grants - g0)}, 0);
    regWrite(3'd5, 32'h4);
    regWrite(3'd3, 32'd1);
    expectItem(32'h900, 2'b10, 32'hA00, 2'b10);
    regWrite(3'd0, mkCtrl(1, 0, 0, 1, 0, 0, 1, 1, 2'b10, 2'b10, 2'b00, 1));
    waitIdle();
    regRead(3'd4, v);
    chk(v == 32'h3, "R10 restart after clear", v, 3);
    regWrite(3'd5, 32'h7);

    // reserved size code
    g0 = grants;
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'd0;
    regWdata = mkCtrl(1, 0, 0, 1, 0, 0, 1, 1, 2'b00, 2'b11, 2'b00, 1);
    @(negedge clk);
    regWr = 1'b0;
    regRead(3'd4, v);
    chk(v == 32'h4, "R11 error flag next cycle", v, 4);
    repeat (20) @(negedge clk);
    regRead(3'd0, v);
    chk(v[0] == 1'b0 && grants == g0, "R11 no transfer", {v[0], 8'(grants - g0)}, 0);

    chk(expQ.size() == 0, "R2 all expected items seen", expQ.size(), 0);
    done = 1;
    summary();
    $finish;
  end

endmodule